// File: doc/BRIEF.md
# Lane-Partitioned Adder with Carry-Word Result

This block adds two 64-bit operands as a set of independent lanes. The lane width can be 8, 16, 32 or 64 bits. No shared carry flag exists. The carry-out of every lane is collected into a second word that has the same width as the operands. In that word each lane's carry sits in the lowest bit of the lane, so a later lane-wise add can use the carry word directly as a plain operand.

A 2-bit operation code decides how the two results leave the block. In the paired mode, the sum and the carry word appear together on two result ports. In the split-in-time mode, the sum appears first and the carry word follows one cycle later. Two further codes compute the same addition but return only the sum or only the carry word, which lets a decoder issue them as two separate operations. A subtract control makes each lane compute a minus b. In that case the carry word holds a borrow per lane.

An internal two-state machine (`ST_IDLE`, `ST_CARRY_PEND`) sequences the split-in-time mode. The transition `ST_IDLE -> ST_CARRY_PEND` is taken when an operation is accepted with code 01. The transition `ST_CARRY_PEND -> ST_IDLE` is always taken on the next clock. Every other accepted operation keeps the machine in `ST_IDLE`.

Top module: `simd_carry_adder`

## Requirements
- R1: `in_lane` picks the lane width: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits. Each lane of `sum_out` is (a + b) modulo 2^width of that lane, and no carry crosses a lane boundary.
- R2: For a lane that starts at bit position p, `carry_out[p]` holds that lane's carry-out. All bits of `carry_out` that are not a lane's lowest bit are 0.
- R3: Op code 00 (paired): one cycle after acceptance, `sum_valid` and `carry_valid` are both 1 for exactly one cycle, and the two words belong to the same operation.
- R4: Op code 01 (split in time): one cycle after acceptance, `sum_valid` is 1 with the sum. On the following cycle, `carry_valid` is 1 with the carry word. The two valids are never high together in this mode.
- R5: `busy` is 1 for exactly the single cycle that follows acceptance of an op-01 operation. An `in_valid` seen in that cycle is dropped and produces no result.
- R6: Op code 10 gives only `sum_valid` with the sum. Op code 11 gives only `carry_valid` with the carry word on `carry_out`. Both arrive one cycle after acceptance.
- R7: With `in_sub` = 1, each lane computes a - b modulo 2^width. The carry word then holds a per-lane borrow equal to NOT carry, which is 1 exactly when the lane's unsigned a < b.
- R8: While reset is asserted, and on the first cycle after it, `busy`, `sum_valid` and `carry_valid` are 0.
- R9: `sum_out` is 0 whenever `sum_valid` is 0, and `carry_out` is 0 whenever `carry_valid` is 0. With no accepted input and no pending carry, both valids are 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation request |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand (subtrahend when subtracting) |
| in_lane | input | 2 | Lane width code |
| in_op | input | 2 | Result delivery code: 00 paired, 01 split in time, 10 sum only, 11 carry only |
| in_sub | input | 1 | 1 = lane-wise subtract |
| busy | output | 1 | Carry word pending; input is not accepted |
| sum_valid | output | 1 | `sum_out` holds a result |
| sum_out | output | 64 | Lane-wise sum or difference |
| carry_valid | output | 1 | `carry_out` holds a result |
| carry_out | output | 64 | Per-lane carry or borrow at each lane's lowest bit |

## Verification
The adder is driven with all-ones plus one operands, where a chained carry would ripple through the whole word. These show whether lane boundaries really cut the chain at each of the four widths. Alternating byte patterns and random words separate a carry placed at the wrong bit of its lane from a carry that is simply missing. Equal operands under subtract separate the borrow from the raw carry. Back-to-back requests with `in_valid` held high during the split-in-time mode show whether the request made during `busy` is dropped. Mixed sequences of all four op codes show whether the valid strobes line up with the right words.

// File: rtl/simd_carry_pkg.sv
package simd_carry_pkg;

    typedef enum logic [1:0] {
        LANE_W8  = 2'b00,
        LANE_W16 = 2'b01,
        LANE_W32 = 2'b10,
        LANE_W64 = 2'b11
    } lane_e;

    typedef enum logic [1:0] {
        OP_PAIRED     = 2'b00,
        OP_SPLIT_TIME = 2'b01,
        OP_SUM_ONLY   = 2'b10,
        OP_CARRY_ONLY = 2'b11
    } op_e;

    typedef enum logic {
        ST_IDLE       = 1'b0,
        ST_CARRY_PEND = 1'b1
    } state_e;

endpackage

// File: rtl/simd_lane_boundary.sv
module simd_lane_boundary
    import simd_carry_pkg::*;
#(
    parameter int BYTES = 8
) (
    input  lane_e             lane,
    output logic [BYTES-1:0]  lane_start
);
    // A byte slice opens a lane when its index is aligned to the lane size in bytes.
    for (genvar g = 0; g < BYTES; g++) begin : g_start
        always_comb begin
            unique case (lane)
                LANE_W8:  lane_start[g] = 1'b1;
                LANE_W16: lane_start[g] = ((g % 2) == 0);
                LANE_W32: lane_start[g] = ((g % 4) == 0);
                LANE_W64: lane_start[g] = ((g % 8) == 0);
            endcase
        end
    end
endmodule

// File: rtl/simd_slice_adder.sv
module simd_slice_adder
    import simd_carry_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int BYTES = DATA_W / 8
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              sub,
    input  lane_e             lane,
    input  logic [BYTES-1:0]  lane_start,
    output logic [DATA_W-1:0] sum,
    output logic [DATA_W-1:0] carry_word
);
    logic [BYTES-1:0] slice_cin;
    logic [BYTES-1:0] slice_cout;
    logic [DATA_W-1:0] b_eff;

    assign b_eff = sub ? ~op_b : op_b;

    // Byte slices with a carry chain that is cut at every lane start.
    for (genvar g = 0; g < BYTES; g++) begin : g_slice
        if (g == 0) begin : g_first
            assign slice_cin[g] = sub;
        end else begin : g_rest
            assign slice_cin[g] = lane_start[g] ? sub : slice_cout[g-1];
        end
        assign {slice_cout[g], sum[g*8 +: 8]} =
            {1'b0, op_a[g*8 +: 8]} + {1'b0, b_eff[g*8 +: 8]} + {8'd0, slice_cin[g]};
    end

    // The carry of the lane's top slice is placed at the lane's lowest bit.
    always_comb begin
        carry_word = '0;
        for (int i = 0; i < BYTES; i++) begin
            if (lane_start[i]) begin
                unique case (lane)
                    LANE_W8:  carry_word[i*8] = slice_cout[i]     ^ sub;
                    LANE_W16: carry_word[i*8] = slice_cout[i | 1] ^ sub;
                    LANE_W32: carry_word[i*8] = slice_cout[i | 3] ^ sub;
                    LANE_W64: carry_word[i*8] = slice_cout[i | 7] ^ sub;
                endcase
            end
        end
    end
endmodule

// File: rtl/simd_carry_adder.sv
module simd_carry_adder
    import simd_carry_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [1:0]        in_lane,
    input  logic [1:0]        in_op,
    input  logic              in_sub,
    output logic              busy,
    output logic              sum_valid,
    output logic [DATA_W-1:0] sum_out,
    output logic              carry_valid,
    output logic [DATA_W-1:0] carry_out
);
    localparam int BYTES = DATA_W / 8;
    localparam logic [DATA_W-1:0] LSB_MASK = {BYTES{8'h01}};

    state_e            state_q, state_n;
    logic [BYTES-1:0]  lane_start;
    logic [DATA_W-1:0] add_sum, add_carry, pend_carry_q;
    logic              accept;
    lane_e             lane;
    op_e               op;

    assign lane   = lane_e'(in_lane);
    assign op     = op_e'(in_op);
    assign accept = in_valid && (state_q == ST_IDLE);
    assign busy   = (state_q == ST_CARRY_PEND);

    simd_lane_boundary #(.BYTES(BYTES)) boundary_i (
        .lane       (lane),
        .lane_start (lane_start)
    );

    simd_slice_adder #(.DATA_W(DATA_W)) adder_i (
        .op_a       (in_a),
        .op_b       (in_b),
        .sub        (in_sub),
        .lane       (lane),
        .lane_start (lane_start),
        .sum        (add_sum),
        .carry_word (add_carry)
    );

    // Next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:       if (accept && op == OP_SPLIT_TIME) state_n = ST_CARRY_PEND;
            ST_CARRY_PEND: state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_valid    <= 1'b0;
            sum_out      <= '0;
            carry_valid  <= 1'b0;
            carry_out    <= '0;
            pend_carry_q <= '0;
        end else begin
            sum_valid   <= 1'b0;
            sum_out     <= '0;
            carry_valid <= 1'b0;
            carry_out   <= '0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        unique case (op)
                            OP_PAIRED: begin
                                sum_valid   <= 1'b1;
                                sum_out     <= add_sum;
                                carry_valid <= 1'b1;
                                carry_out   <= add_carry;
                            end
                            OP_SPLIT_TIME: begin
                                sum_valid    <= 1'b1;
                                sum_out      <= add_sum;
                                pend_carry_q <= add_carry;
                            end
                            OP_SUM_ONLY: begin
                                sum_valid <= 1'b1;
                                sum_out   <= add_sum;
                            end
                            OP_CARRY_ONLY: begin
                                carry_valid <= 1'b1;
                                carry_out   <= add_carry;
                            end
                        endcase
                    end
                end
                ST_CARRY_PEND: begin
                    carry_valid <= 1'b1;
                    carry_out   <= pend_carry_q;
                end
            endcase
        end
    end

    assert_busy_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    assert_busy_drops_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !sum_valid);
    assert_sum_before_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (sum_valid && !carry_valid));
    assert_carry_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> carry_valid);
    assert_carry_lsb_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        carry_valid |-> ((carry_out & ~LSB_MASK) == '0));
    assert_sum_zero_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sum_valid |-> (sum_out == '0));
    assert_carry_zero_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_valid |-> (carry_out == '0));
endmodule

// File: tb/simd_carry_adder_tb.sv
module simd_carry_adder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_a = '0, in_b = '0;
    logic [1:0]  in_lane = '0, in_op = '0;
    logic        in_sub = 1'b0;
    logic        busy, sum_valid, carry_valid;
    logic [63:0] sum_out, carry_out;

    int checks = 0;
    int failures = 0;
    string cur_req = "R8";
    bit done = 0;

    always #5 clk = ~clk;

    simd_carry_adder dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_lane(in_lane), .in_op(in_op), .in_sub(in_sub), .busy(busy),
        .sum_valid(sum_valid), .sum_out(sum_out), .carry_valid(carry_valid),
        .carry_out(carry_out)
    );

    // Reference arithmetic, one lane at a time.
    function automatic void ref_add(input logic [63:0] a, input logic [63:0] b,
                                    input logic [1:0] lane, input logic sub,
                                    output logic [63:0] s, output logic [63:0] c);
        int nb;
        logic [64:0] msk, xa, xb, t;
        nb = 8 << lane;
        msk = (65'd1 << nb) - 65'd1;
        s = '0;
        c = '0;
        for (int base = 0; base < 64; base += nb) begin
            xa = ({1'b0, a} >> base) & msk;
            xb = ({1'b0, (sub ? ~b : b)} >> base) & msk;
            t  = xa + xb + {64'd0, sub};
            s  = s | 64'((t & msk) << base);
            c[base] = t[nb] ^ sub;
        end
    endfunction

    // Cycle model
    logic        m_sv, m_cv, m_busy, m_pend;
    logic [63:0] m_s, m_c, m_pc;
    always @(posedge clk or negedge rst_n) begin
        logic [63:0] rs, rc;
        if (!rst_n) begin
            m_sv <= 0; m_cv <= 0; m_busy <= 0; m_pend <= 0;
            m_s <= '0; m_c <= '0; m_pc <= '0;
        end else begin
            ref_add(in_a, in_b, in_lane, in_sub, rs, rc);
            m_sv <= 0; m_cv <= 0; m_busy <= 0; m_s <= '0; m_c <= '0;
            if (m_pend) begin
                m_cv <= 1; m_c <= m_pc; m_pend <= 0;
            end else if (in_valid) begin
                case (in_op)
                    2'b00: begin m_sv <= 1; m_s <= rs; m_cv <= 1; m_c <= rc; end
                    2'b01: begin m_sv <= 1; m_s <= rs; m_pc <= rc; m_pend <= 1; m_busy <= 1; end
                    2'b10: begin m_sv <= 1; m_s <= rs; end
                    default: begin m_cv <= 1; m_c <= rc; end
                endcase
            end
        end
    end

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    // Compare every cycle, away from the clock edge.
    always @(negedge clk) begin
        if (!done) begin
            chk("busy(R5)", {63'd0, busy}, {63'd0, m_busy});
            chk("sum_valid(R3/R4/R6)", {63'd0, sum_valid}, {63'd0, m_sv});
            chk("carry_valid(R3/R4/R6)", {63'd0, carry_valid}, {63'd0, m_cv});
            chk("sum_out(R1/R9)", sum_out, m_s);
            chk("carry_out(R2/R9)", carry_out, m_c);
        end
    end

    task automatic drive(input logic v, input logic [63:0] a, input logic [63:0] b,
                         input logic [1:0] lane, input logic [1:0] op, input logic sub);
        @(negedge clk);
        in_valid = v; in_a = a; in_b = b; in_lane = lane; in_op = op; in_sub = sub;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired in %s", cur_req);
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R8: reset state
        cur_req = "R8";
        repeat (3) @(negedge clk);
        chk("busy in reset R8", {63'd0, busy}, 64'd0);
        chk("valids in reset R8", {62'd0, sum_valid, carry_valid}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1/R2: carry ripple boundaries at each lane width, paired mode
        cur_req = "R1";
        for (int l = 0; l < 4; l++) begin
            drive(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'(l), 2'b00, 0);
            drive(1, 64'h80FF_7FFF_0080_FF01, 64'h8001_8001_FF80_01FF, 2'(l), 2'b00, 0);
        end
        cur_req = "R2";
        for (int l = 0; l < 4; l++)
            drive(1, 64'hAA55_AA55_AA55_AA55, 64'h55AB_55AB_55AB_55AB, 2'(l), 2'b00, 0);
        // R3: paired, random
        cur_req = "R3";
        for (int k = 0; k < 40; k++)
            drive(1, {$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom), 2'b00, 0);
        // R4: split in time with idle gaps
        cur_req = "R4";
        for (int k = 0; k < 20; k++) begin
            drive(1, {$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom), 2'b01, 0);
            drive(0, '0, '0, 0, 0, 0);
        end
        // R5: in_valid held high across busy; dropped request must leave no trace
        cur_req = "R5";
        for (int k = 0; k < 30; k++)
            drive(1, {$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom), 2'($urandom % 2), 0);
        // R6: sum-only and carry-only
        cur_req = "R6";
        for (int k = 0; k < 30; k++)
            drive(1, {$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom), 2'(2 + k % 2), 0);
        // R7: subtract, equal operands, a<b, random
        cur_req = "R7";
        for (int l = 0; l < 4; l++) begin
            drive(1, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 2'(l), 2'b00, 1);
            drive(1, 64'h0001_0001_0001_0001, 64'h0002_0000_0100_0002, 2'(l), 2'b00, 1);
        end
        for (int k = 0; k < 40; k++)
            drive(1, {$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom), 2'($urandom), 1);
        // R9: idle cycles after activity
        cur_req = "R9";
        for (int k = 0; k < 5; k++) drive(0, {$urandom, $urandom}, {$urandom, $urandom}, 0, 0, 0);
        // Mixed run
        cur_req = "R3";
        for (int k = 0; k < 400; k++)
            drive($urandom % 4 != 0, {$urandom, $urandom}, {$urandom, $urandom},
                  2'($urandom), 2'($urandom), 1'($urandom));
        drive(0, '0, '0, 0, 0, 0);
        repeat (3) @(negedge clk);
        @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule